// File: doc/BRIEF.md
# Descriptor Retirement and Completion Tracker

This block follows a ring of transmit descriptors as a DMA engine consumes them. Software posts descriptors, which moves a tail index and an "added" count. The engine reports how far it has read through a hardware head index. The tracker walks its own head index toward the hardware head, one descriptor per clock. Each step raises a "removed" count that never goes backwards. Beside the ring it keeps a small in-order queue of outstanding requests. Each queued request names its first descriptor, the index one past its last descriptor, and a tag. When the walking head lands on the front request's end index, that request is retired with an OK completion. Descriptors that no request claims are stepped over silently.

Two events turn the queue into an abort drain. A cleanup command first finishes the walk up to the hardware head value captured with the command. It then returns every remaining request as ABORTED, in order, and sets the ring state back to its origin. A request pushed while the engine is not running is queued with zero indices, and the whole queue is then returned as ABORTED in push order. The ring pointers are left untouched in that case. Completions leave on a valid/ready port, and the walk pauses rather than lose a completion.

Top module: `desc_retire_tracker`

## Requirements
- R1: While in normal mode and `sw_head` differs from `hw_head`, `sw_head` advances by exactly one per clock. It goes from RING_DEPTH-1 to 0, and `removed_cnt` rises by one on each step.
- R2: `removed_cnt` never decreases. It changes only by +1 per step, or by the resynchronisation of R8.
- R3: When a step moves `sw_head` onto the end index of the oldest queued request, that request is presented one clock later on the completion port. It carries its tag, start and end indices, with `cpl_aborted` = 0 (OK). The next queued request then becomes the oldest.
- R4: A descriptor that is not the end of the oldest request is retired with no completion. Exactly one completion leaves per pushed request.
- R5: `progress` is 1 in the clock after each head step and 0 otherwise.
- R6: While `cpl_valid` is 1 and `cpl_ready` is 0, the completion fields hold. The walk stops before any step that would produce a further completion, although steps over unclaimed descriptors continue.
- R7: A `clean_req` seen in normal mode captures `hw_head`. The tracker walks to that index, issuing OK completions, and then completes every request still queued with `cpl_aborted` = 1, in queue order.
- R8: At the end of a cleanup, `removed_cnt` equals `added_cnt`, and `sw_head`, `sw_tail` and `ring_gen` are all 0.
- R9: A request pushed while `running` is 0 is queued with start and end 0. Every queued request, earlier ones included, is then completed with `cpl_aborted` = 1 in push order. Head, tail and the counters are left unchanged.
- R10: A pulse on `post_en` (with `post_num` ≤ RING_DEPTH) adds `post_num` to `added_cnt` and to `sw_tail` modulo RING_DEPTH. It increments the 2-bit `ring_gen` each time the tail wraps.
- R11: `req_ready` is 1 only in normal mode with fewer than Q_DEPTH requests queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| running | input | 1 | Engine is running; pushes while low are aborted |
| hw_head | input | IDX_W | Head index reported by the engine |
| post_en | input | 1 | Software posts descriptors this clock |
| post_num | input | IDX_W+1 | Number of descriptors posted |
| req_valid | input | 1 | Request push valid |
| req_ready | output | 1 | Request push accepted |
| req_start | input | IDX_W | First descriptor of the request |
| req_end | input | IDX_W | Index one past the request's last descriptor |
| req_tag | input | TAG_W | Request tag |
| cpl_valid | output | 1 | Completion valid |
| cpl_ready | input | 1 | Completion accepted |
| cpl_tag | output | TAG_W | Tag of the completed request |
| cpl_start | output | IDX_W | Start index of the completed request |
| cpl_end | output | IDX_W | End index of the completed request |
| cpl_aborted | output | 1 | 0 = OK, 1 = ABORTED |
| clean_req | input | 1 | Cleanup command (one-clock pulse) |
| progress | output | 1 | A descriptor was retired in the previous clock |
| sw_head | output | IDX_W | Tracker head index |
| sw_tail | output | IDX_W | Tail index from posts |
| ring_gen | output | 2 | Tail wrap generation |
| removed_cnt | output | CNT_W | Retired descriptor count |
| added_cnt | output | CNT_W | Posted descriptor count |

## Verification
The hardest case to reach from the ports is a walk that pauses part way round the ring. An OK completion sits unaccepted while the next request's end index is still ahead and unclaimed descriptors lie between them. A second case is a cleanup that lands on a queue holding some requests that still retire OK and some that must abort. The stimulus holds `cpl_ready` low before moving `hw_head`, so the head stops one short of the second request's end. It fills the queue to capacity before it issues `clean_req` with a hardware head that covers only half of the queue. A separate phase pushes while `running` is low, behind a request already queued, and checks that both come back aborted and that the ring pointers keep their values.

// File: rtl/drt_pkg.sv
`timescale 1ns/1ps
package drt_pkg;

  typedef enum logic [1:0] {
    MODE_RUN    = 2'd0,
    MODE_SETTLE = 2'd1,
    MODE_FLUSH  = 2'd2
  } drt_mode_e;

  localparam logic CPL_OK    = 1'b0;
  localparam logic CPL_ABORT = 1'b1;

endpackage

// File: rtl/drt_ring_ptrs.sv
`timescale 1ns/1ps
module drt_ring_ptrs #(
  parameter int unsigned RING_DEPTH = 16,
  parameter int unsigned CNT_W      = 16,
  localparam int unsigned IDX_W     = $clog2(RING_DEPTH),
  localparam int unsigned NUM_W     = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_en,
  input  logic             post_en,
  input  logic [NUM_W-1:0] post_num,
  input  logic             resync,
  output logic [IDX_W-1:0] head,
  output logic [IDX_W-1:0] head_nxt,
  output logic [IDX_W-1:0] tail,
  output logic [1:0]       gen,
  output logic [CNT_W-1:0] removed,
  output logic [CNT_W-1:0] added
);

  localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(RING_DEPTH - 1);
  localparam logic [NUM_W:0]   DEPTH_EXT = (NUM_W + 1)'(RING_DEPTH);

  logic [IDX_W-1:0] head_q, head_d;
  logic [IDX_W-1:0] tail_q, tail_d;
  logic [1:0]       gen_q, gen_d;
  logic [CNT_W-1:0] removed_q, removed_d;
  logic [CNT_W-1:0] added_q, added_d;

  logic [NUM_W:0]   tail_sum;
  logic [NUM_W:0]   tail_fold;
  logic             tail_wrap;
  logic [IDX_W-1:0] head_step;

  always_comb begin
    head_step = (head_q == LAST_IDX) ? '0 : head_q + 1'b1;
    tail_sum  = {2'b00, tail_q} + {1'b0, post_num};
    tail_wrap = (tail_sum >= DEPTH_EXT);
    tail_fold = tail_wrap ? (tail_sum - DEPTH_EXT) : tail_sum;
  end

  always_comb begin
    head_d    = head_q;
    tail_d    = tail_q;
    gen_d     = gen_q;
    removed_d = removed_q;
    added_d   = added_q;
    if (resync) begin
      head_d    = '0;
      tail_d    = '0;
      gen_d     = '0;
      removed_d = added_q;
    end else begin
      if (step_en) begin
        head_d    = head_step;
        removed_d = removed_q + 1'b1;
      end
      if (post_en) begin
        tail_d  = tail_fold[IDX_W-1:0];
        gen_d   = gen_q + {1'b0, tail_wrap};
        added_d = added_q + CNT_W'(post_num);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q    <= '0;
      tail_q    <= '0;
      gen_q     <= '0;
      removed_q <= '0;
      added_q   <= '0;
    end else begin
      head_q    <= head_d;
      tail_q    <= tail_d;
      gen_q     <= gen_d;
      removed_q <= removed_d;
      added_q   <= added_d;
    end
  end

  assign head     = head_q;
  assign head_nxt = head_step;
  assign tail     = tail_q;
  assign gen      = gen_q;
  assign removed  = removed_q;
  assign added    = added_q;

  AST_HEAD_IN_RING: assert property (@(posedge clk) disable iff (!rst_n)
    head_q <= LAST_IDX); // R1

  AST_REMOVED_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
    !resync |=> (removed_q - $past(removed_q)) <= CNT_W'(1)); // R2

endmodule

// File: rtl/drt_req_fifo.sv
`timescale 1ns/1ps
module drt_req_fifo #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned W     = 8,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);

  localparam logic [AW-1:0] LAST_SLOT = AW'(DEPTH - 1);
  localparam logic [AW:0]   DEPTH_CNT = (AW + 1)'(DEPTH);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [AW:0]   cnt_q, cnt_d;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (push) wr_d = (wr_q == LAST_SLOT) ? '0 : wr_q + 1'b1;
    if (pop)  rd_d = (rd_q == LAST_SLOT) ? '0 : rd_q + 1'b1;
    if (push && !pop)      cnt_d = cnt_q + 1'b1;
    else if (pop && !push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem_q[wr_q] <= din;
  end

  assign dout  = mem_q[rd_q];
  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == DEPTH_CNT);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full); // R11

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty); // R7

endmodule

// File: rtl/desc_retire_tracker.sv
`timescale 1ns/1ps
module desc_retire_tracker
  import drt_pkg::*;
#(
  parameter int unsigned RING_DEPTH = 16,
  parameter int unsigned Q_DEPTH    = 4,
  parameter int unsigned TAG_W      = 4,
  parameter int unsigned CNT_W      = 16,
  localparam int unsigned IDX_W     = $clog2(RING_DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             running,
  input  logic [IDX_W-1:0] hw_head,
  input  logic             post_en,
  input  logic [IDX_W:0]   post_num,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [IDX_W-1:0] req_start,
  input  logic [IDX_W-1:0] req_end,
  input  logic [TAG_W-1:0] req_tag,
  output logic             cpl_valid,
  input  logic             cpl_ready,
  output logic [TAG_W-1:0] cpl_tag,
  output logic [IDX_W-1:0] cpl_start,
  output logic [IDX_W-1:0] cpl_end,
  output logic             cpl_aborted,
  input  logic             clean_req,
  output logic             progress,
  output logic [IDX_W-1:0] sw_head,
  output logic [IDX_W-1:0] sw_tail,
  output logic [1:0]       ring_gen,
  output logic [CNT_W-1:0] removed_cnt,
  output logic [CNT_W-1:0] added_cnt
);

  typedef struct packed {
    logic             dead;
    logic [TAG_W-1:0] tag;
    logic [IDX_W-1:0] first;
    logic [IDX_W-1:0] last;
  } entry_t;

  localparam int unsigned ENT_W = $bits(entry_t);

  drt_mode_e        mode_q, mode_d;
  logic [IDX_W-1:0] settle_q, settle_d;
  logic             wipe_q, wipe_d;
  logic             resync;

  logic             cpl_valid_q, cpl_valid_d;
  logic [TAG_W-1:0] cpl_tag_q;
  logic [IDX_W-1:0] cpl_start_q, cpl_end_q;
  logic             cpl_aborted_q;
  logic             progress_q;

  entry_t           push_ent, front;
  logic [ENT_W-1:0] fifo_dout;
  logic             fifo_empty, fifo_full;
  logic             push, pop;

  logic [IDX_W-1:0] head_cur, head_nxt;
  logic             walking, hit, emit_ok, step, flush_pop, post_ok;

  assign front = entry_t'(fifo_dout);

  // request intake
  always_comb begin
    req_ready      = (mode_q == MODE_RUN) && !fifo_full;
    push           = req_valid && req_ready;
    push_ent.dead  = !running;
    push_ent.tag   = req_tag;
    push_ent.first = running ? req_start : '0;
    push_ent.last  = running ? req_end   : '0;
    post_ok        = post_en && (mode_q == MODE_RUN);
  end

  // retirement walk and queue pop
  always_comb begin
    walking   = ((mode_q == MODE_RUN)    && (head_cur != hw_head)) ||
                ((mode_q == MODE_SETTLE) && (head_cur != settle_q));
    hit       = !fifo_empty && !front.dead && (front.last == head_nxt);
    emit_ok   = !cpl_valid_q || cpl_ready;
    step      = walking && (!hit || emit_ok);
    flush_pop = (mode_q == MODE_FLUSH) && !fifo_empty && emit_ok;
    pop       = (step && hit) || flush_pop;
  end

  // mode sequencing
  always_comb begin
    mode_d   = mode_q;
    settle_d = settle_q;
    wipe_d   = wipe_q;
    resync   = 1'b0;
    unique case (mode_q)
      MODE_RUN: begin
        if (clean_req) begin
          mode_d   = MODE_SETTLE;
          settle_d = hw_head;
          wipe_d   = 1'b1;
        end else if (push && !running) begin
          mode_d = MODE_FLUSH;
          wipe_d = 1'b0;
        end
      end
      MODE_SETTLE: begin
        if (head_cur == settle_q) mode_d = MODE_FLUSH;
      end
      MODE_FLUSH: begin
        if (fifo_empty) begin
          mode_d = MODE_RUN;
          resync = wipe_q;
          wipe_d = 1'b0;
        end
      end
      default: mode_d = MODE_RUN;
    endcase
  end

  always_comb begin
    cpl_valid_d = cpl_valid_q;
    if (pop)            cpl_valid_d = 1'b1;
    else if (cpl_ready) cpl_valid_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q        <= MODE_RUN;
      settle_q      <= '0;
      wipe_q        <= 1'b0;
      cpl_valid_q   <= 1'b0;
      cpl_tag_q     <= '0;
      cpl_start_q   <= '0;
      cpl_end_q     <= '0;
      cpl_aborted_q <= CPL_OK;
      progress_q    <= 1'b0;
    end else begin
      mode_q      <= mode_d;
      settle_q    <= settle_d;
      wipe_q      <= wipe_d;
      cpl_valid_q <= cpl_valid_d;
      progress_q  <= step;
      if (pop) begin
        cpl_tag_q     <= front.tag;
        cpl_start_q   <= front.first;
        cpl_end_q     <= front.last;
        cpl_aborted_q <= (mode_q == MODE_FLUSH) ? CPL_ABORT : CPL_OK;
      end
    end
  end

  drt_ring_ptrs #(
    .RING_DEPTH (RING_DEPTH),
    .CNT_W      (CNT_W)
  ) u_ptrs (
    .clk      (clk),
    .rst_n    (rst_n),
    .step_en  (step),
    .post_en  (post_ok),
    .post_num (post_num),
    .resync   (resync),
    .head     (head_cur),
    .head_nxt (head_nxt),
    .tail     (sw_tail),
    .gen      (ring_gen),
    .removed  (removed_cnt),
    .added    (added_cnt)
  );

  drt_req_fifo #(
    .DEPTH (Q_DEPTH),
    .W     (ENT_W)
  ) u_queue (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push),
    .din   (push_ent),
    .pop   (pop),
    .dout  (fifo_dout),
    .empty (fifo_empty),
    .full  (fifo_full)
  );

  assign sw_head     = head_cur;
  assign cpl_valid   = cpl_valid_q;
  assign cpl_tag     = cpl_tag_q;
  assign cpl_start   = cpl_start_q;
  assign cpl_end     = cpl_end_q;
  assign cpl_aborted = cpl_aborted_q;
  assign progress    = progress_q;

  AST_CPL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_valid_q && !cpl_ready) |=>
      (cpl_valid_q && $stable(cpl_tag_q) && $stable(cpl_aborted_q) && $stable(cpl_end_q))); // R6

  AST_PROGRESS_MOVED: assert property (@(posedge clk) disable iff (!rst_n)
    progress_q |-> (head_cur != $past(head_cur))); // R5

  AST_FLUSH_FROZEN_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == MODE_FLUSH) && !fifo_empty) |=> $stable(head_cur)); // R9

endmodule

// File: tb/desc_retire_tracker_test.sv
`timescale 1ns/1ps
module desc_retire_tracker_test;

  localparam int RING = 16;
  localparam int QD   = 4;
  localparam int TW   = 4;
  localparam int CW   = 16;
  localparam int IW   = $clog2(RING);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          running;
  logic [IW-1:0] hw_head;
  logic          post_en;
  logic [IW:0]   post_num;
  logic          req_valid;
  logic          req_ready;
  logic [IW-1:0] req_start, req_end;
  logic [TW-1:0] req_tag;
  logic          cpl_valid, cpl_ready;
  logic [TW-1:0] cpl_tag;
  logic [IW-1:0] cpl_start, cpl_end;
  logic          cpl_aborted;
  logic          clean_req;
  logic          progress;
  logic [IW-1:0] sw_head, sw_tail;
  logic [1:0]    ring_gen;
  logic [CW-1:0] removed_cnt, added_cnt;

  always #2.5 clk = ~clk;

  desc_retire_tracker #(
    .RING_DEPTH (RING), .Q_DEPTH (QD), .TAG_W (TW), .CNT_W (CW)
  ) uut (
    .clk (clk), .rst_n (rst_n), .running (running), .hw_head (hw_head),
    .post_en (post_en), .post_num (post_num),
    .req_valid (req_valid), .req_ready (req_ready), .req_start (req_start),
    .req_end (req_end), .req_tag (req_tag),
    .cpl_valid (cpl_valid), .cpl_ready (cpl_ready), .cpl_tag (cpl_tag),
    .cpl_start (cpl_start), .cpl_end (cpl_end), .cpl_aborted (cpl_aborted),
    .clean_req (clean_req), .progress (progress),
    .sw_head (sw_head), .sw_tail (sw_tail), .ring_gen (ring_gen),
    .removed_cnt (removed_cnt), .added_cnt (added_cnt)
  );

  typedef struct {
    int    tag;
    int    first;
    int    last;
    int    aborted;
    string req;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int errors = 0;
  int seen   = 0;

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // scoreboard monitor: compares each accepted completion with the oldest expectation
  initial begin
    forever begin
      @(negedge clk);
      #0.5;
      if (rst_n && cpl_valid && cpl_ready) begin
        seen++;
        if (exp_q.size() == 0) begin
          checks++;
          errors++;
          $display("FAIL R4 unexpected completion actual_tag=%0d expected=none", cpl_tag);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(e.req, "completion tag",    int'(cpl_tag),     e.tag);
          check(e.req, "completion start",  int'(cpl_start),   e.first);
          check(e.req, "completion end",    int'(cpl_end),     e.last);
          check(e.req, "completion status", int'(cpl_aborted), e.aborted);
        end
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic post(input int n);
    post_en  = 1'b1;
    post_num = (IW + 1)'(n);
    @(negedge clk);
    post_en  = 1'b0;
  endtask

  task automatic push(input int s, input int e, input int t, input int ab, input string req);
    exp_t x;
    check("R11", "req_ready before push", int'(req_ready), 1);
    x.tag     = t;
    x.first   = running ? s : 0;
    x.last    = running ? e : 0;
    x.aborted = ab;
    x.req     = req;
    exp_q.push_back(x);
    req_valid = 1'b1;
    req_start = IW'(s);
    req_end   = IW'(e);
    req_tag   = TW'(t);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog R7 actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; running = 1'b1; hw_head = '0; post_en = 1'b0; post_num = '0;
    req_valid = 1'b0; req_start = '0; req_end = '0; req_tag = '0;
    cpl_ready = 1'b1; clean_req = 1'b0;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);

    // reset state
    check("R1",  "reset head",     int'(sw_head), 0);
    check("R10", "reset tail",     int'(sw_tail), 0);
    check("R10", "reset gen",      int'(ring_gen), 0);
    check("R2",  "reset removed",  int'(removed_cnt), 0);
    check("R3",  "reset cpl_valid", int'(cpl_valid), 0);
    check("R5",  "reset progress", int'(progress), 0);
    check("R11", "reset req_ready", int'(req_ready), 1);

    // phase 1: two requests with an unclaimed descriptor (index 2) between them
    post(5);
    check("R10", "tail after post 5", int'(sw_tail), 5);
    check("R10", "added after post 5", int'(added_cnt), 5);
    push(0, 2, 1, 0, "R3");
    push(3, 5, 2, 0, "R3");
    hw_head = IW'(5);
    cyc(1);
    check("R1", "head after first step", int'(sw_head), 1);
    check("R5", "progress after step",   int'(progress), 1);
    cyc(7);
    check("R1", "head reached hw_head", int'(sw_head), 5);
    check("R1", "removed after walk",   int'(removed_cnt), 5);
    check("R5", "progress when idle",   int'(progress), 0);
    check("R4", "completions so far",   seen, 2);
    check("R4", "expectations left",    exp_q.size(), 0);

    // phase 2: request spanning the ring wrap
    post(14);
    check("R10", "tail after wrap",  int'(sw_tail), 3);
    check("R10", "gen after wrap",   int'(ring_gen), 1);
    check("R10", "added after wrap", int'(added_cnt), 19);
    push(5, 1, 3, 0, "R3");
    hw_head = IW'(3);
    cyc(18);
    check("R1", "head after wrapping walk", int'(sw_head), 3);
    check("R1", "removed after wrap",       int'(removed_cnt), 19);
    check("R3", "wrap completion seen",     seen, 3);

    // phase 3: completion back-pressure
    cpl_ready = 1'b0;
    post(4);
    push(3, 4, 4, 0, "R6");
    push(4, 6, 5, 0, "R6");
    hw_head = IW'(7);
    cyc(8);
    check("R6", "head stalled before second end", int'(sw_head), 5);
    check("R6", "removed while stalled",          int'(removed_cnt), 21);
    check("R6", "held cpl_valid",                 int'(cpl_valid), 1);
    check("R6", "held cpl_tag",                   int'(cpl_tag), 4);
    cpl_ready = 1'b1;
    cyc(6);
    check("R6", "head after release",    int'(sw_head), 7);
    check("R6", "removed after release", int'(removed_cnt), 23);

    // phase 4: fill the queue, then cleanup covering half of it
    post(8);
    push(7, 9, 6, 0, "R7");
    push(9, 11, 7, 0, "R7");
    push(11, 13, 8, 1, "R7");
    push(13, 15, 9, 1, "R7");
    check("R11", "req_ready when full", int'(req_ready), 0);
    hw_head   = IW'(11);
    clean_req = 1'b1;
    cyc(1);
    clean_req = 1'b0;
    hw_head   = '0;
    cyc(20);
    check("R8", "head after cleanup",    int'(sw_head), 0);
    check("R8", "tail after cleanup",    int'(sw_tail), 0);
    check("R8", "gen after cleanup",     int'(ring_gen), 0);
    check("R8", "removed equals added",  int'(removed_cnt), 31);
    check("R8", "added kept",            int'(added_cnt), 31);
    check("R7", "completions after cleanup", seen, 9);
    check("R5", "progress after cleanup", int'(progress), 0);

    // phase 5: push while the engine is stopped
    post(2);
    push(0, 2, 10, 1, "R9");
    running = 1'b0;
    push(5, 5, 11, 1, "R9");
    cyc(8);
    running = 1'b1;
    check("R9", "head untouched",    int'(sw_head), 0);
    check("R9", "tail untouched",    int'(sw_tail), 2);
    check("R9", "removed untouched", int'(removed_cnt), 31);
    check("R9", "added untouched",   int'(added_cnt), 33);
    check("R11", "ready after abort drain", int'(req_ready), 1);

    for (int i = 0; i < 50 && exp_q.size() != 0; i++) cyc(1);
    check("R7", "outstanding expectations", exp_q.size(), 0);
    check("R4", "total completions", seen, 11);
    finish_run();
  end

endmodule